// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is the serial slave side of a 64-word by 16-bit nonvolatile store. The store itself is modelled as a register array. The chip select, serial clock and serial data inputs are sampled into the system clock domain, and a rising serial clock shifts one bit in. The serial output comes with a separate drive enable, so it can be wired to a tri-state pad.

Every instruction begins with a 1 start bit. Two opcode bits follow, then six bits that carry either the address or, when the opcode is 00, an extended opcode in the upper two of those six bits.

Data changes only when chip select falls after a write, erase, write-all or erase-all instruction. That falling edge starts a self-timed programming interval of a set number of system clocks. While the interval runs, the device ignores all instructions and drives the data output low whenever it is selected.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, writes are disabled, every word reads 0xFFFF, and the data output is not driven.
- R2: Opcode 10 is a read. On the rising clock that samples the last address bit, the output becomes driven and low (a dummy 0). Each later rising clock presents the next bit of the addressed word, MSB first.
- R3: If chip select stays high after a read, the following words are output with no dummy bit, at rising addresses. The address wraps from 63 to 0.
- R4: Opcode 01 followed by a 16-bit word writes that word at the given address. The write happens on the chip select falling edge and only while writes are enabled.
- R5: Extended opcode 11 (bits 00 11 after the start bit) enables writes. Extended opcode 00 disables them. While writes are disabled, write, erase, write-all and erase-all change no word and start no busy interval.
- R6: Opcode 11 erases the addressed word to 0xFFFF.
- R7: Further 16-bit words after the first word of a write go to rising addresses. The address wraps inside its aligned 8-word page: only the low 3 address bits advance.
- R8: Extended opcode 10 sets every word to 0xFFFF. Extended opcode 01, followed by a 16-bit word, writes that word to every location.
- R9: During the programming interval, a selected device drives the output low. Once the interval ends, it drives the output high until the next start bit.
- R10: Zeros clocked in before the start bit are skipped.
- R11: Instructions received during programming have no effect.
- R12: While chip select is low, the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out and ready status |
| do_oe | output | 1 | Drive enable for do_o |

## Verification
The bench uses the default 64-word, 16-bit, 8-word-page geometry, so both wrap points can be reached: the 63-to-0 wrap in continuous read and the within-page wrap of a page write. It sets the programming interval to 400 system clocks. That is long enough for a complete 9-bit instruction, including its chip select fall, to arrive while the device is busy. It is also short enough that every program-and-read-back sequence completes quickly.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PAGE_AW     = 3,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int NWORDS = 1 << AW;
  localparam int PWORDS = 1 << PAGE_AW;
  localparam int CMDW   = AW + 2;
  localparam int CW     = $clog2((DW > CMDW ? DW : CMDW) + 1);
  localparam int PW     = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RD, S_WR, S_HOLD, S_BUSY} state_t;
  typedef enum logic [2:0] {OP_NONE, OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL} op_t;

  state_t state;
  op_t    op;
  logic [2:0] cs_p, sk_p;
  logic [1:0] di_p;
  logic [DW-1:0] mem [NWORDS];
  logic [DW-1:0] wbuf [PWORDS];
  logic [PWORDS-1:0] wval;
  logic [CMDW-2:0] cmd;
  logic [AW-1:0] addr;
  logic [DW-1:0] rsh, wsh;
  logic [CW-1:0] bcnt;
  logic [PW-1:0] pcnt;
  logic wen, poll, dout;

  wire cs_s    = cs_p[1];
  wire di_s    = di_p[1];
  wire sk_rise = sk_p[1] & ~sk_p[2];
  wire [CMDW-1:0] full = {cmd, di_s};
  wire [1:0] f_op  = full[CMDW-1:CMDW-2];
  wire [1:0] f_ext = full[AW-1:AW-2];
  wire [DW-1:0] wnew = {wsh[DW-2:0], di_s};
  wire busy = (state == S_BUSY);
  wire go = wen && (op == OP_ERASE || op == OP_ERAL ||
                    ((op == OP_WRITE || op == OP_WRAL) && |wval));

  assign do_oe = cs_s && (state == S_RD || poll);
  assign do_o  = (state == S_RD) ? dout : !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
      state <= S_IDLE; op <= OP_NONE;
      cmd <= '0; addr <= '0; rsh <= '0; wsh <= '0; bcnt <= '0; pcnt <= '0;
      wen <= 1'b0; poll <= 1'b0; dout <= 1'b0; wval <= '0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
      for (int j = 0; j < PWORDS; j++) wbuf[j] <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs};
      sk_p <= {sk_p[1:0], sk};
      di_p <= {di_p[0], di};
      case (state)
        S_IDLE: if (cs_s && sk_rise && di_s) begin
          state <= S_CMD; bcnt <= '0; poll <= 1'b0; op <= OP_NONE;
        end
        S_CMD: if (!cs_s) state <= S_IDLE;
        else if (sk_rise) begin
          cmd  <= full[CMDW-2:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(CMDW - 1)) begin
            addr <= full[AW-1:0];
            bcnt <= '0;
            wval <= '0;
            case (f_op)
              2'b10: begin state <= S_RD; rsh <= mem[full[AW-1:0]]; dout <= 1'b0; end
              2'b01: begin state <= S_WR; op <= OP_WRITE; end
              2'b11: begin state <= S_HOLD; op <= OP_ERASE; end
              default: case (f_ext)
                2'b11: begin wen <= 1'b1; state <= S_HOLD; end
                2'b00: begin wen <= 1'b0; state <= S_HOLD; end
                2'b10: begin op <= OP_ERAL; state <= S_HOLD; end
                default: begin op <= OP_WRAL; state <= S_WR; addr <= '0; end
              endcase
            endcase
          end
        end
        S_RD: if (!cs_s) state <= S_IDLE;
        else if (sk_rise) begin
          dout <= rsh[DW-1];
          rsh  <= rsh << 1;
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(DW - 1)) begin
            addr <= addr + 1'b1;
            rsh  <= mem[addr + 1'b1];
            bcnt <= '0;
          end
        end
        S_BUSY: if (pcnt == '0) state <= S_IDLE; else pcnt <= pcnt - 1'b1;
        default: if (!cs_s) begin
          if (go) begin
            for (int i = 0; i < NWORDS; i++) begin
              if (op == OP_ERAL) mem[i] <= '1;
              if (op == OP_WRAL) mem[i] <= wbuf[0];
              if (op == OP_ERASE && i == int'(addr)) mem[i] <= '1;
            end
            if (op == OP_WRITE)
              for (int j = 0; j < PWORDS; j++)
                if (wval[j]) mem[(int'(addr) & ~(PWORDS - 1)) + j] <= wbuf[j];
            state <= S_BUSY; pcnt <= PW'(PROG_CYCLES - 1); poll <= 1'b1;
          end else state <= S_IDLE;
        end else if (state == S_WR && sk_rise) begin
          wsh  <= wnew;
          bcnt <= bcnt + 1'b1;
          if (bcnt == CW'(DW - 1)) begin
            wbuf[addr[PAGE_AW-1:0]] <= wnew;
            wval[addr[PAGE_AW-1:0]] <= 1'b1;
            addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + 1'b1;
            bcnt <= '0;
            if (op == OP_WRAL) state <= S_HOLD;
          end
        end
      endcase
    end
  end

  // R5
  wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pcnt != '0) |=> busy);
  // R2
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_RD) |-> (!do_o && (do_oe || !cs_s)));
  // R7
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && cs_s && sk_rise && bcnt == CW'(DW - 1)) |=>
      addr[AW-1:PAGE_AW] == $past(addr[AW-1:PAGE_AW]));
  // R12
  cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && $past(!cs_s)) |-> !do_oe);
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int PROG = 400;
  logic clk = 0, rst_n = 0, cs = 0, sk = 0, di = 0;
  wire do_o, do_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] model [64];

  always #2 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  task automatic chk(bit ok, string r, int act, int expv);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%h expected=%h", r, act, expv); end
  endtask

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic bitx(input logic d, output logic q);
    di = d; wclk(5); sk = 1; wclk(10); q = do_o; sk = 0; wclk(5);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) bitx(v[i], q);
  endtask

  task automatic cs_on;  cs = 1; wclk(5); endtask
  task automatic cs_off; cs = 0; wclk(6); endtask

  task automatic instr(input logic [1:0] op, input logic [5:0] a);
    cs_on; send({23'd0, 1'b1, op, a}, 9); cs_off;
  endtask

  task automatic rd_check(input int a, input int n, input int nz, input string r);
    logic q; logic [15:0] w; logic [8:0] v;
    v = {3'b110, 6'(a)};
    cs_on;
    if (nz > 0) send(0, nz);
    send({23'd0, v} >> 1, 8);
    bitx(v[0], q);
    chk(q == 0 && do_oe, "R2 dummy", {do_oe, q}, 2);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin bitx(0, q); w = {w[14:0], q}; end
      chk(w == model[(a + k) % 64], r, w, model[(a + k) % 64]);
    end
    cs_off;
    chk(!do_oe, "R12", do_oe, 0);
  endtask

  task automatic wait_prog(string r);
    cs_on;
    chk(do_oe && !do_o, r, {do_oe, do_o}, 2);
    wclk(PROG);
    chk(do_oe && do_o, r, {do_oe, do_o}, 3);
    cs_off;
  endtask

  task automatic t_reset;
    chk(!do_oe, "R1", do_oe, 0);
    rd_check(5, 1, 0, "R1");
  endtask

  task automatic t_disabled;
    cs_on; send({23'd0, 9'b101000011}, 9); send(16'h1234, 16); cs_off;
    cs_on; chk(!(do_oe && !do_o), "R5 no busy", {do_oe, do_o}, 0); cs_off;
    rd_check(3, 1, 0, "R5");
  endtask

  task automatic t_write_busy;
    instr(2'b00, 6'b110000);
    cs_on; send({23'd0, 9'b101000011}, 9); send(16'h1234, 16); cs_off;
    model[3] = 16'h1234;
    cs_on; chk(do_oe && !do_o, "R9 busy", {do_oe, do_o}, 2); cs_off;
    instr(2'b11, 6'd3);
    cs_on; chk(do_oe && !do_o, "R9 busy", {do_oe, do_o}, 2);
    wclk(PROG);
    chk(do_oe && do_o, "R9 ready", {do_oe, do_o}, 3);
    cs_off;
    rd_check(3, 1, 0, "R4 R11");
  endtask

  task automatic t_zeros;
    rd_check(3, 1, 3, "R10");
  endtask

  task automatic t_page;
    cs_on; send({23'd0, 9'b101001110}, 9);
    send(16'h1111, 16); send(16'h2222, 16); send(16'h3333, 16); cs_off;
    model[14] = 16'h1111; model[15] = 16'h2222; model[8] = 16'h3333;
    wait_prog("R9");
    rd_check(8, 8, 0, "R7");
  endtask

  task automatic t_wrap;
    cs_on; send({23'd0, 9'b101111110}, 9); send(16'h6262, 16); send(16'h6363, 16); cs_off;
    model[62] = 16'h6262; model[63] = 16'h6363;
    wait_prog("R9");
    rd_check(62, 3, 0, "R3");
  endtask

  task automatic t_erase;
    instr(2'b11, 6'd14);
    model[14] = 16'hFFFF;
    wait_prog("R9");
    rd_check(13, 3, 0, "R6");
  endtask

  task automatic t_all;
    cs_on; send({23'd0, 9'b100010000}, 9); send(16'hA5A5, 16); cs_off;
    for (int i = 0; i < 64; i++) model[i] = 16'hA5A5;
    wait_prog("R9");
    rd_check(0, 2, 0, "R8 wral");
    rd_check(40, 1, 0, "R8 wral");
    instr(2'b00, 6'b100000);
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    wait_prog("R9");
    rd_check(62, 3, 0, "R8 eral");
  endtask

  task automatic t_ewds;
    instr(2'b00, 6'b000000);
    cs_on; send({23'd0, 9'b101000101}, 9); send(16'hBEEF, 16); cs_off;
    cs_on; chk(!(do_oe && !do_o), "R5 no busy", {do_oe, do_o}, 0); cs_off;
    rd_check(5, 1, 0, "R5");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    wclk(4); rst_n = 1; wclk(4);
    t_reset;
    t_disabled;
    t_write_busy;
    t_zeros;
    t_page;
    t_wrap;
    t_erase;
    t_all;
    t_ewds;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wclk(150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule